// File: doc/BRIEF.md
# OSD paged register access controller

This block sits between a processor's byte-wide bus and the state of an on-screen display. It holds the display's control registers and its 80-byte cell memory. It decodes single-cycle read and write strobes into register and memory updates, and it returns read data one cycle later. Most of the display state is reached through a 64-byte window at the bottom of the address space. A page register chooses which of two display pages appears in that window. The page register, the display enable and the character bank register have fixed addresses outside the window.

The first page holds 64 character-code cells. The bus may write these cells but cannot read them back. The display side reads them through its own port. The second page holds 16 attribute cells at offsets 00h-0Fh and five control registers at offsets 10h-14h, all readable and writable. While the display is enabled, the window and the bank register are locked. The processor can then change only the enable and the page selection.

Top module: `osd_bus_ctrl`

## Requirements
- R1: After reset, the bus read data, the enable output and the write acknowledge are 0. The page register, the bank register, the control registers and all 80 memory cells are also 0.
- R2: The page register at E8h is 8 bits wide. It can be written and read at any time, including while the display is enabled.
- R3: The enable register at E9h keeps bit 0 of the written byte, and `osd_en` follows it one cycle after the write. It can be written at any time. A read returns the enable in bit 0, with bits 7:1 at 0.
- R4: With page 6 selected (page register bit 6 = 1, bit 5 = 0) and the display off, window offsets 10h-14h are five 8-bit control registers that can be written and read.
- R5: With page 6 selected and the display off, window offsets 00h-0Fh are attribute cells 64-79. A write is visible on a later bus read and on the display port at cell index 64 + offset.
- R6: With page register bit 5 = 1 and the display off, a write to window offset n (00h-3Fh) stores character cell n, which is visible on the display port. A bus read of any window offset returns 00h.
- R7: With the display off, the bank register at EDh is 8 bits wide and can be written and read.
- R8: While `osd_en` = 1, writes to the window and to EDh change nothing and give no acknowledge, and reads of them return 00h. After the display is turned off, the earlier values read back unchanged.
- R9: When page register bits 5 and 6 are both 1, page 5 is mapped. Writes reach character cells and not attribute cells, and window reads return 00h.
- R10: When page register bits 5 and 6 are both 0, window writes change nothing and give no acknowledge, and window reads return 00h.
- R11: Reads of unmapped addresses (page 6 offsets 15h-3Fh, and any address above 3Fh other than E8h, E9h and EDh) return 00h.
- R12: `rdata` changes only on the clock edge that samples `rd_en`, and it holds between reads. `wr_ok` is high for exactly the one cycle after an accepted write and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 8 | Bus address |
| wdata | input | 8 | Bus write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rdata | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| wr_ok | output | 1 | One-cycle pulse after an accepted write |
| osd_en | output | 1 | Display enable (bit 0 of E9h) |
| disp_addr | input | 7 | Display-side cell index, 0-79 |
| disp_data | output | 8 | Cell content at `disp_addr`, combinational, 00h beyond cell 79 |

## Verification
A wrong page decode shows up on the next read or display-port lookup of the cell or register it hits. The data appears in the wrong cell, or a write-only page leaks data. A lock flag that is lost or set at the wrong time shows the cycle after the access. Either `wr_ok` pulses when it should not, or a locked read returns a stored value instead of 00h. Damage done while locked also shows after the display is turned off, because the earlier values must read back unchanged. The bench therefore pairs each write with a read-back or a display-port lookup, and it checks neighbouring cells so that writes reaching the wrong place are caught.

// File: rtl/osd_pkg.sv
package osd_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PAGE,
    ACC_GEN,
    ACC_BANK,
    ACC_CHR,
    ACC_FMT,
    ACC_CREG
  } acc_kind_t;

  typedef struct packed {
    acc_kind_t  kind;
    logic [7:0] idx;
  } acc_dec_t;
endpackage

// File: rtl/osd_addr_dec.sv
module osd_addr_dec
  import osd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] PAGE_ADDR = 8'hE8,
  parameter logic [AW-1:0] GEN_ADDR = 8'hE9,
  parameter logic [AW-1:0] BANK_ADDR = 8'hED,
  parameter int CHR_CELLS = 64,
  parameter int FMT_CELLS = 16,
  parameter int NCREG = 5,
  parameter int CREG_BASE = 16,
  parameter int CHR_BIT = 5,
  parameter int FMT_BIT = 6
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] page_sel,
  output acc_dec_t      dec
);
  localparam int WIN_BITS = 6;

  logic       in_win;
  logic [7:0] off;

  assign in_win = (addr >> WIN_BITS) == '0;
  assign off    = 8'(addr[WIN_BITS-1:0]);

  always_comb begin
    dec.kind = ACC_NONE;
    dec.idx  = '0;
    if (addr == PAGE_ADDR) begin
      dec.kind = ACC_PAGE;
    end else if (addr == GEN_ADDR) begin
      dec.kind = ACC_GEN;
    end else if (addr == BANK_ADDR) begin
      dec.kind = ACC_BANK;
    end else if (in_win) begin
      // page 5 wins when both page bits are set
      if (page_sel[CHR_BIT]) begin
        if (off < 8'(CHR_CELLS)) begin
          dec.kind = ACC_CHR;
          dec.idx  = off;
        end
      end else if (page_sel[FMT_BIT]) begin
        if (off < 8'(FMT_CELLS)) begin
          dec.kind = ACC_FMT;
          dec.idx  = off + 8'(CHR_CELLS);
        end else if (off >= 8'(CREG_BASE) && off < 8'(CREG_BASE + NCREG)) begin
          dec.kind = ACC_CREG;
          dec.idx  = off - 8'(CREG_BASE);
        end
      end
    end
  end
endmodule

// File: rtl/osd_ctrl_regs.sv
module osd_ctrl_regs
  import osd_pkg::*;
#(
  parameter int DW = 8,
  parameter int NCREG = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  acc_dec_t      dec,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] page_q,
  output logic          gen_q,
  output logic [DW-1:0] rd_val
);
  logic [DW-1:0] bank_q, bank_n, page_n;
  logic          gen_n;
  logic [DW-1:0] creg_q [NCREG];
  logic [DW-1:0] creg_n [NCREG];

  always_comb begin
    page_n = page_q;
    gen_n  = gen_q;
    bank_n = bank_q;
    for (int k = 0; k < NCREG; k++) creg_n[k] = creg_q[k];
    if (we) begin
      unique case (dec.kind)
        ACC_PAGE: page_n = wdata;
        ACC_GEN:  gen_n  = wdata[0];
        ACC_BANK: bank_n = wdata;
        ACC_CREG: for (int k = 0; k < NCREG; k++)
                    if (dec.idx == 8'(k)) creg_n[k] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      gen_q  <= 1'b0;
      bank_q <= '0;
      for (int k = 0; k < NCREG; k++) creg_q[k] <= '0;
    end else begin
      page_q <= page_n;
      gen_q  <= gen_n;
      bank_q <= bank_n;
      for (int k = 0; k < NCREG; k++) creg_q[k] <= creg_n[k];
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (dec.kind)
      ACC_PAGE: rd_val = page_q;
      ACC_GEN:  rd_val = DW'(gen_q);
      ACC_BANK: rd_val = bank_q;
      ACC_CREG: for (int k = 0; k < NCREG; k++)
                  if (dec.idx == 8'(k)) rd_val = creg_q[k];
      default: ;
    endcase
  end
endmodule

// File: rtl/osd_cell_ram.sv
module osd_cell_ram #(
  parameter int DW = 8,
  parameter int CELLS = 80,
  parameter int DISP_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [7:0]         idx,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      bus_val,
  input  logic [DISP_AW-1:0] disp_addr,
  output logic [DW-1:0]      disp_data
);
  logic [DW-1:0] cell_q [CELLS];

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    logic cell_en;
    assign cell_en = we && (idx == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q[g] <= '0;
      else if (cell_en) cell_q[g] <= wdata;
    end
  end

  always_comb begin
    bus_val   = '0;
    disp_data = '0;
    for (int k = 0; k < CELLS; k++) begin
      if (idx == 8'(k)) bus_val = cell_q[k];
      if (8'(disp_addr) == 8'(k)) disp_data = cell_q[k];
    end
  end
endmodule

// File: rtl/osd_bus_ctrl.sv
module osd_bus_ctrl
  import osd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] PAGE_ADDR = 8'hE8,
  parameter logic [AW-1:0] GEN_ADDR = 8'hE9,
  parameter logic [AW-1:0] BANK_ADDR = 8'hED,
  parameter int CHR_CELLS = 64,
  parameter int FMT_CELLS = 16,
  parameter int NCREG = 5,
  parameter int CREG_BASE = 16,
  parameter int CHR_BIT = 5,
  parameter int FMT_BIT = 6,
  parameter int DISP_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               rd_en,
  input  logic               wr_en,
  output logic [DW-1:0]      rdata,
  output logic               wr_ok,
  output logic               osd_en,
  input  logic [DISP_AW-1:0] disp_addr,
  output logic [DW-1:0]      disp_data
);
  localparam int CELLS = CHR_CELLS + FMT_CELLS;

  logic [1:0]    rsync_q;
  logic          rst_s;
  acc_dec_t      dec;
  logic [DW-1:0] page_q, reg_val, ram_val;
  logic          gen_q, locked, wr_go, ram_we, reg_we;
  logic [DW-1:0] rd_next, rdata_n, rdata_q;
  logic          wr_ok_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  osd_addr_dec #(
    .AW(AW), .DW(DW), .PAGE_ADDR(PAGE_ADDR), .GEN_ADDR(GEN_ADDR),
    .BANK_ADDR(BANK_ADDR), .CHR_CELLS(CHR_CELLS), .FMT_CELLS(FMT_CELLS),
    .NCREG(NCREG), .CREG_BASE(CREG_BASE), .CHR_BIT(CHR_BIT), .FMT_BIT(FMT_BIT)
  ) u_dec (
    .addr(addr), .page_sel(page_q), .dec(dec)
  );

  always_comb begin
    locked = gen_q && (dec.kind inside {ACC_BANK, ACC_CHR, ACC_FMT, ACC_CREG});
    wr_go  = wr_en && !locked && (dec.kind != ACC_NONE);
    ram_we = wr_go && (dec.kind inside {ACC_CHR, ACC_FMT});
    reg_we = wr_go && !(dec.kind inside {ACC_CHR, ACC_FMT});
  end

  osd_ctrl_regs #(.DW(DW), .NCREG(NCREG)) u_regs (
    .clk(clk), .rst_n(rst_s), .we(reg_we), .dec(dec), .wdata(wdata),
    .page_q(page_q), .gen_q(gen_q), .rd_val(reg_val)
  );

  osd_cell_ram #(.DW(DW), .CELLS(CELLS), .DISP_AW(DISP_AW)) u_ram (
    .clk(clk), .rst_n(rst_s), .we(ram_we), .idx(dec.idx), .wdata(wdata),
    .bus_val(ram_val), .disp_addr(disp_addr), .disp_data(disp_data)
  );

  always_comb begin
    rd_next = '0;
    if (!locked) begin
      unique case (dec.kind)
        ACC_FMT:           rd_next = ram_val;
        ACC_CHR, ACC_NONE: rd_next = '0;
        default:           rd_next = reg_val;
      endcase
    end
    rdata_n = rd_en ? rd_next : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rdata_q <= '0;
      wr_ok_q <= 1'b0;
    end else begin
      rdata_q <= rdata_n;
      wr_ok_q <= wr_go;
    end
  end

  assign rdata  = rdata_q;
  assign wr_ok  = wr_ok_q;
  assign osd_en = gen_q;
endmodule

// File: rtl/osd_bus_ctrl_chk.sv
module osd_bus_ctrl_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] PAGE_ADDR = 8'hE8,
  parameter logic [AW-1:0] GEN_ADDR = 8'hE9,
  parameter int CHR_BIT = 5,
  parameter int FMT_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] rdata,
  input logic          wr_ok,
  input logic          osd_en,
  input logic [DW-1:0] page_sel
);
  logic in_win;
  assign in_win = (addr >> 6) == '0;

  // R2
  page_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PAGE_ADDR) |=> (page_sel == $past(wdata)));

  // R3
  gen_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == GEN_ADDR) |=> (osd_en == $past(wdata[0])));

  // R6
  chr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_win && page_sel[CHR_BIT]) |=> (rdata == '0));

  // R8
  lock_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osd_en && wr_en && in_win) |=> !wr_ok);

  // R8
  lock_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osd_en && rd_en && in_win) |=> (rdata == '0));

  // R10
  nopage_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_win && !page_sel[CHR_BIT] && !page_sel[FMT_BIT]) |=> (rdata == '0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R12
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_ok);
endmodule

bind osd_bus_ctrl osd_bus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_s), .addr(addr), .wdata(wdata), .rd_en(rd_en),
  .wr_en(wr_en), .rdata(rdata), .wr_ok(wr_ok), .osd_en(osd_en),
  .page_sel(page_q)
);

// File: tb/sim_osd_bus_ctrl.sv
`timescale 1ns/1ps
module sim_osd_bus_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] disp_addr = '0;
  logic [7:0] rdata, disp_data;
  logic       wr_ok, osd_en;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       pend = 1'b0;

  always #2.5 clk = ~clk;

  osd_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .rdata(rdata), .wr_ok(wr_ok), .osd_en(osd_en),
    .disp_addr(disp_addr), .disp_data(disp_data)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result the cycle after its strobe
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read result %02h", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic disp(input logic [6:0] a, input logic [7:0] e, input string tag);
    disp_addr = a; #1;
    chk(disp_data, e, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rdata, 8'h00, "R1 rdata");
    chk({7'b0, osd_en}, 8'h00, "R1 osd_en");
    chk({7'b0, wr_ok}, 8'h00, "R1 wr_ok");
    disp(7'd0, 8'h00, "R1 cell0");
    disp(7'd79, 8'h00, "R1 cell79");
    rd(8'hE8, 8'h00, "R1 page reg");
    rd(8'hED, 8'h00, "R1 bank reg");

    // R2 page register
    wr(8'hE8, 8'h20);
    chk({7'b0, wr_ok}, 8'h01, "R12 ack after write");
    @(negedge clk);
    chk({7'b0, wr_ok}, 8'h00, "R12 ack one cycle");
    rd(8'hE8, 8'h20, "R2 page readback");

    // R6 character page
    wr(8'h05, 8'h2A);
    disp(7'd5, 8'h2A, "R6 char cell 5");
    disp(7'd4, 8'h00, "R6 char cell 4 untouched");
    rd(8'h05, 8'h00, "R6 write-only read");

    // R5 attribute cells, R4 control registers
    wr(8'hE8, 8'h40);
    wr(8'h03, 8'h5C);
    rd(8'h03, 8'h5C, "R5 attr readback");
    disp(7'd67, 8'h5C, "R5 attr cell 67");
    for (int k = 0; k < 5; k++) wr(8'h10 + 8'(k), 8'h11 + 8'(k));
    for (int k = 0; k < 5; k++) rd(8'h10 + 8'(k), 8'h11 + 8'(k), "R4 ctrl reg");
    rd(8'h15, 8'h00, "R11 unmapped offset");
    rd(8'hE0, 8'h00, "R11 unmapped address");

    // R7 bank register
    wr(8'hED, 8'h03);
    rd(8'hED, 8'h03, "R7 bank readback");

    // R9 both page bits
    wr(8'hE8, 8'h60);
    rd(8'h03, 8'h00, "R9 page5 priority read");
    wr(8'h07, 8'h33);
    disp(7'd7, 8'h33, "R9 char cell 7");
    disp(7'd71, 8'h00, "R9 attr cell 71 untouched");

    // R10 no page bits
    wr(8'hE8, 8'h00);
    wr(8'h02, 8'h77);
    chk({7'b0, wr_ok}, 8'h00, "R10 no ack");
    rd(8'h03, 8'h00, "R10 window read");
    wr(8'hE8, 8'h40);
    rd(8'h02, 8'h00, "R10 attr 66 untouched");

    // R3 enable, R8 lock
    wr(8'hE9, 8'hFF);
    chk({7'b0, osd_en}, 8'h01, "R3 osd_en set");
    rd(8'hE9, 8'h01, "R3 enable readback");
    wr(8'h10, 8'hAA);
    chk({7'b0, wr_ok}, 8'h00, "R8 locked no ack");
    rd(8'h10, 8'h00, "R8 locked read");
    rd(8'h03, 8'h00, "R8 locked attr read");
    wr(8'hED, 8'hFF);
    rd(8'hED, 8'h00, "R8 locked bank read");
    wr(8'hE8, 8'h20);
    wr(8'h09, 8'h44);
    disp(7'd9, 8'h00, "R8 locked char write");
    wr(8'hE8, 8'h40);
    rd(8'hE8, 8'h40, "R2 page write while enabled");
    wr(8'hE9, 8'h00);
    chk({7'b0, osd_en}, 8'h00, "R3 osd_en clear");
    rd(8'h10, 8'h11, "R8 ctrl reg kept");
    rd(8'hED, 8'h03, "R8 bank kept");

    // R12 read data holds between reads
    repeat (3) @(negedge clk);
    chk(rdata, 8'h03, "R12 rdata hold");

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule